// File: doc/BRIEF.md
# CAN Controller Interrupt Request Aggregator

This block gathers the interrupt events of a single CAN controller and turns them into interrupt requests for the processor's interrupt controller. Each message slot reports a one-cycle pulse when it finishes sending or receiving a frame. The protocol engine reports three error events as pulses: a bus error was seen, the node entered error-passive, and the node went bus-off. Each pulse sets a sticky status bit. Every status bit has its own mask bit. The OR of all unmasked status bits forms one combined request level.

A rising edge on the combined level is accepted only while all three request flags are clear. When it is accepted, all three flags are set together. The same edge also sets each interrupt-controller IR output whose enable bit is 1. Hardware never clears a status bit, a request flag or an IR bit. Software clears them by writing zeros through a small register port. While a request is outstanding, any further source is hidden. A new interrupt appears only after software has cleared both the flags and the status bits.

Top module: `canirq_agg`

## Requirements
- R1: A pulse on `slot_evt[k]` sets slot status bit k (register address 0). The bit stays 1 until software writes address 0 with bit k = 0. Writing 1 to a bit leaves it unchanged.
- R2: `err_evt` bit 0 (bus error), bit 1 (error-passive) and bit 2 (bus-off) set the matching bits of the error status register (address 2). These bits clear only by a write of 0 to the bit.
- R3: The slot mask (address 1) and error mask (address 3) are read/write. `irq_line` is 1 exactly when some status bit and its mask bit are both 1. It follows the status register in the same cycle.
- R4: When `irq_line` rises and all request flags are 0, the three request flags (address 4, bits 2:0) all become 1 on the next clock edge.
- R5: On that same edge, `ir_out[j]` becomes 1 for each j whose enable bit (address 5, bit j) is 1. `ir_out[j]` then stays high until software writes address 6 with bit j = 0.
- R6: While `irq_line` is already 1, newly set unmasked status bits change neither the request flags nor `ir_out`.
- R7: A rising edge of `irq_line` while any request flag is still 1 is ignored. It changes neither the flags nor `ir_out`.
- R8: Hardware never clears status bits or request flags. Without a software write to their address, they can only keep or gain 1s.
- R9: If an event pulse and a software clear reach the same status bit in the same cycle, the bit ends up 1.
- R10: A synchronous active-low reset clears all status, mask, flag, enable and IR registers and the edge-detect register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_evt | input | N_SLOTS | Per-slot transfer-complete pulses |
| err_evt | input | 3 | Error pulses: bus error, error-passive, bus-off |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | N_SLOTS | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | N_SLOTS | Register read data (combinational) |
| irq_line | output | 1 | Combined masked request level |
| ir_out | output | 3 | Interrupt-controller IR bits (levels) |

## Verification
The bench builds the block with its defaults: 16 message slots, three request/enable pairs and a 16-bit register port. With these values every slot bit, every error kind and every enable pattern can be reached in a short run. The vector table walks one full request life cycle. That cycle covers a fresh edge, hidden later sources, a partial clear that leaves the flags set so a new edge is blocked, and a fresh edge after a full clear. Directed tests cover the masked-off case, the set-versus-clear collision on a status bit and the reset.

// File: rtl/canirq_pkg.sv
package canirq_pkg;

  typedef enum logic [2:0] {
    A_SLOT_STS = 3'd0,
    A_SLOT_MSK = 3'd1,
    A_ERR_STS  = 3'd2,
    A_ERR_MSK  = 3'd3,
    A_REQ_FLG  = 3'd4,
    A_REQ_EN   = 3'd5,
    A_IR       = 3'd6
  } reg_addr_e;

  localparam int unsigned FN_W = 32;

  // Sticky status update: new events are ORed in after the software clear,
  // so a set in the same cycle always survives.
  function automatic logic [FN_W-1:0] sticky_next(
    input logic [FN_W-1:0] cur,
    input logic [FN_W-1:0] set,
    input logic            clr_wr,
    input logic [FN_W-1:0] wdata
  );
    logic [FN_W-1:0] kept;
    kept = clr_wr ? (cur & wdata) : cur;
    return kept | set;
  endfunction

  function automatic logic any_unmasked(
    input logic [FN_W-1:0] sts,
    input logic [FN_W-1:0] msk
  );
    return |(sts & msk);
  endfunction

endpackage

// File: rtl/canirq_stsbank.sv
module canirq_stsbank
  import canirq_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         sts_wr_i,
  input  logic         msk_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] sts_o,
  output logic [W-1:0] msk_o,
  output logic         hit_o
);

  logic [FN_W-1:0] sts_nx_full;

  always_comb begin
    sts_nx_full = sticky_next(FN_W'(sts_o), FN_W'(set_i), sts_wr_i, FN_W'(wdata_i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_o <= '0;
      msk_o <= '0;
    end else begin
      sts_o <= sts_nx_full[W-1:0];
      if (msk_wr_i) msk_o <= wdata_i;
    end
  end

  assign hit_o = any_unmasked(FN_W'(sts_o), FN_W'(msk_o));

endmodule

// File: rtl/canirq_edge.sv
module canirq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/canirq_fanout.sv
module canirq_fanout #(
  parameter int unsigned N_REQ = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             flg_wr_i,
  input  logic             en_wr_i,
  input  logic             ir_wr_i,
  input  logic [N_REQ-1:0] wdata_i,
  output logic [N_REQ-1:0] flags_o,
  output logic [N_REQ-1:0] en_o,
  output logic [N_REQ-1:0] ir_o,
  output logic             accept_o
);

  // An edge counts only when every request flag has been cleared.
  assign accept_o = rise_i & ~(|flags_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_o <= '0;
      en_o    <= '0;
    end else begin
      if (accept_o)      flags_o <= '1;
      else if (flg_wr_i) flags_o <= flags_o & wdata_i;
      if (en_wr_i) en_o <= wdata_i;
    end
  end

  for (genvar j = 0; j < N_REQ; j++) begin : g_ir
    always_ff @(posedge clk) begin
      if (!rst_n)                      ir_o[j] <= 1'b0;
      else if (accept_o && en_o[j])    ir_o[j] <= 1'b1;
      else if (ir_wr_i && !wdata_i[j]) ir_o[j] <= 1'b0;
    end
  end

endmodule

// File: rtl/canirq_agg.sv
module canirq_agg
  import canirq_pkg::*;
#(
  parameter int unsigned N_SLOTS = 16,
  parameter int unsigned N_ERR   = 3,
  parameter int unsigned N_REQ   = 3,
  parameter int unsigned AW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] slot_evt,
  input  logic [N_ERR-1:0]   err_evt,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [N_SLOTS-1:0] wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [N_SLOTS-1:0] rd_data,
  output logic               irq_line,
  output logic [N_REQ-1:0]   ir_out
);

  localparam int unsigned DW = N_SLOTS;

  logic [N_SLOTS-1:0] slot_sts, slot_msk;
  logic [N_ERR-1:0]   err_sts, err_msk;
  logic [N_REQ-1:0]   req_flags, req_en;
  logic               slot_hit, err_hit;
  logic               req_rise, req_accept;

  logic wr_slot_sts, wr_slot_msk, wr_err_sts, wr_err_msk;
  logic wr_flg, wr_en_reg, wr_ir;

  assign wr_slot_sts = wr_en && (wr_addr == A_SLOT_STS);
  assign wr_slot_msk = wr_en && (wr_addr == A_SLOT_MSK);
  assign wr_err_sts  = wr_en && (wr_addr == A_ERR_STS);
  assign wr_err_msk  = wr_en && (wr_addr == A_ERR_MSK);
  assign wr_flg      = wr_en && (wr_addr == A_REQ_FLG);
  assign wr_en_reg   = wr_en && (wr_addr == A_REQ_EN);
  assign wr_ir       = wr_en && (wr_addr == A_IR);

  canirq_stsbank #(.W(N_SLOTS)) u_slot (
    .clk(clk), .rst_n(rst_n), .set_i(slot_evt),
    .sts_wr_i(wr_slot_sts), .msk_wr_i(wr_slot_msk), .wdata_i(wr_data),
    .sts_o(slot_sts), .msk_o(slot_msk), .hit_o(slot_hit)
  );

  canirq_stsbank #(.W(N_ERR)) u_err (
    .clk(clk), .rst_n(rst_n), .set_i(err_evt),
    .sts_wr_i(wr_err_sts), .msk_wr_i(wr_err_msk), .wdata_i(wr_data[N_ERR-1:0]),
    .sts_o(err_sts), .msk_o(err_msk), .hit_o(err_hit)
  );

  assign irq_line = slot_hit | err_hit;

  canirq_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(irq_line), .rise_o(req_rise)
  );

  canirq_fanout #(.N_REQ(N_REQ)) u_fan (
    .clk(clk), .rst_n(rst_n), .rise_i(req_rise),
    .flg_wr_i(wr_flg), .en_wr_i(wr_en_reg), .ir_wr_i(wr_ir),
    .wdata_i(wr_data[N_REQ-1:0]),
    .flags_o(req_flags), .en_o(req_en), .ir_o(ir_out), .accept_o(req_accept)
  );

  always_comb begin
    case (rd_addr)
      A_SLOT_STS: rd_data = slot_sts;
      A_SLOT_MSK: rd_data = slot_msk;
      A_ERR_STS:  rd_data = DW'(err_sts);
      A_ERR_MSK:  rd_data = DW'(err_msk);
      A_REQ_FLG:  rd_data = DW'(req_flags);
      A_REQ_EN:   rd_data = DW'(req_en);
      A_IR:       rd_data = DW'(ir_out);
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/canirq_agg_chk.sv
module canirq_agg_chk #(
  parameter int unsigned N_SLOTS = 16,
  parameter int unsigned N_ERR   = 3,
  parameter int unsigned N_REQ   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_SLOTS-1:0] slot_evt,
  input logic [N_ERR-1:0]   err_evt,
  input logic [N_SLOTS-1:0] slot_sts,
  input logic [N_ERR-1:0]   err_sts,
  input logic [N_REQ-1:0]   req_flags,
  input logic [N_REQ-1:0]   req_en,
  input logic [N_REQ-1:0]   ir_out,
  input logic               irq_line,
  input logic               req_rise,
  input logic               req_accept,
  input logic               wr_slot_sts,
  input logic               wr_err_sts,
  input logic               wr_flg,
  input logic               wr_ir
);

  p_slot_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_slot_sts |=> ((slot_sts & $past(slot_sts)) == $past(slot_sts)));

  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_err_sts |=> ((err_sts & $past(err_sts)) == $past(err_sts)));

  p_flags_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flg |=> ((req_flags & $past(req_flags)) == $past(req_flags)));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_evt != '0) |=> ((slot_sts & $past(slot_evt)) == $past(slot_evt)));

  p_flags_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> (&req_flags));

  p_ir_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> ((ir_out & $past(req_en)) == $past(req_en)));

  p_no_edge_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line && !req_rise && !wr_ir) |=> $stable(ir_out));

  p_blocked_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && (|req_flags) && !wr_ir) |=> $stable(ir_out));

endmodule

bind canirq_agg canirq_agg_chk #(
  .N_SLOTS(N_SLOTS), .N_ERR(N_ERR), .N_REQ(N_REQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_evt(slot_evt), .err_evt(err_evt),
  .slot_sts(slot_sts), .err_sts(err_sts), .req_flags(req_flags),
  .req_en(req_en), .ir_out(ir_out), .irq_line(irq_line),
  .req_rise(req_rise), .req_accept(req_accept),
  .wr_slot_sts(wr_slot_sts), .wr_err_sts(wr_err_sts),
  .wr_flg(wr_flg), .wr_ir(wr_ir)
);

// File: tb/test_canirq_agg.sv
`timescale 1ns/1ps
module test_canirq_agg;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] slot_evt = '0;
  logic [2:0]  err_evt = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq_line;
  logic [2:0]  ir_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  canirq_agg i_canirq_agg (
    .clk(clk), .rst_n(rst_n), .slot_evt(slot_evt), .err_evt(err_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_line(irq_line), .ir_out(ir_out)
  );

  typedef struct packed {
    logic [15:0] slot;
    logic [2:0]  err;
    logic        wr;
    logic [2:0]  addr;
    logic [15:0] wdata;
    logic        exp_irq;
    logic [2:0]  exp_ir;
  } vec_t;

  // Masks all open, enable = 3'b101 before the walk.
  localparam vec_t TBL [15] = '{
    '{16'h0008, 3'b000, 1'b0, 3'd0, 16'h0000, 1'b1, 3'b000}, // R1/R3 slot event raises line
    '{16'h0000, 3'b000, 1'b0, 3'd0, 16'h0000, 1'b1, 3'b101}, // R4/R5 edge accepted
    '{16'h0000, 3'b010, 1'b0, 3'd0, 16'h0000, 1'b1, 3'b101}, // R6 extra source hidden
    '{16'h0000, 3'b000, 1'b1, 3'd6, 16'h0000, 1'b1, 3'b000}, // R5 software clears IR
    '{16'h0000, 3'b000, 1'b0, 3'd0, 16'h0000, 1'b1, 3'b000}, // R6 no re-raise
    '{16'h0000, 3'b000, 1'b1, 3'd0, 16'h0000, 1'b1, 3'b000}, // R1 slot cleared, error remains
    '{16'h0000, 3'b000, 1'b1, 3'd2, 16'h0000, 1'b0, 3'b000}, // R2 error cleared
    '{16'h0000, 3'b000, 1'b0, 3'd0, 16'h0000, 1'b0, 3'b000},
    '{16'h0001, 3'b000, 1'b0, 3'd0, 16'h0000, 1'b1, 3'b000}, // R7 edge while flags set
    '{16'h0000, 3'b000, 1'b0, 3'd0, 16'h0000, 1'b1, 3'b000}, // R7 ignored
    '{16'h0000, 3'b000, 1'b1, 3'd4, 16'h0000, 1'b1, 3'b000}, // R8 flags cleared by write only
    '{16'h0000, 3'b000, 1'b1, 3'd0, 16'h0000, 1'b0, 3'b000},
    '{16'h0000, 3'b000, 1'b0, 3'd0, 16'h0000, 1'b0, 3'b000},
    '{16'h0000, 3'b100, 1'b0, 3'd0, 16'h0000, 1'b1, 3'b000}, // R2 bus-off event
    '{16'h0000, 3'b000, 1'b0, 3'd0, 16'h0000, 1'b1, 3'b101}  // R4/R5 fresh edge accepted
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    for (int a = 0; a < 7; a++) rd_chk(3'(a), 16'h0000, "R10 reset reg");
    check("R10 reset irq", {15'b0, irq_line}, 16'h0);
    check("R10 reset ir", {13'b0, ir_out}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 masked: status set but line stays low
    slot_evt = 16'h0004;
    @(negedge clk);
    slot_evt = '0;
    rd_chk(3'd0, 16'h0004, "R1 slot status set");
    check("R3 masked line low", {15'b0, irq_line}, 16'h0);
    @(negedge clk);
    rd_chk(3'd0, 16'h0004, "R8 slot status holds");
    wr_reg(3'd0, 16'hFFFB);
    rd_chk(3'd0, 16'h0000, "R1 write-0 clears");

    // R9 collision: event and clear on the same bit
    slot_evt = 16'h0020; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0000;
    @(negedge clk);
    slot_evt = '0; wr_en = 1'b0;
    rd_chk(3'd0, 16'h0020, "R9 set wins");
    wr_reg(3'd0, 16'h0000);

    // R2 error bits
    err_evt = 3'b001;
    @(negedge clk);
    err_evt = '0;
    rd_chk(3'd2, 16'h0001, "R2 bus error bit0");
    wr_reg(3'd2, 16'h0006);
    rd_chk(3'd2, 16'h0000, "R2 write-0 clears");

    // Open masks, enables 101
    wr_reg(3'd1, 16'hFFFF);
    wr_reg(3'd3, 16'h0007);
    wr_reg(3'd5, 16'h0005);
    rd_chk(3'd1, 16'hFFFF, "R3 slot mask readback");
    rd_chk(3'd3, 16'h0007, "R3 error mask readback");
    check("R3 line low idle", {15'b0, irq_line}, 16'h0);

    for (int i = 0; i < 15; i++) begin
      slot_evt = TBL[i].slot; err_evt = TBL[i].err;
      wr_en = TBL[i].wr; wr_addr = TBL[i].addr; wr_data = TBL[i].wdata;
      @(negedge clk);
      slot_evt = '0; err_evt = '0; wr_en = 1'b0; wr_data = '0;
      #1;
      check($sformatf("R3-R7 vec%0d irq_line", i), {15'b0, irq_line}, {15'b0, TBL[i].exp_irq});
      check($sformatf("R5 vec%0d ir_out", i), {13'b0, ir_out}, {13'b0, TBL[i].exp_ir});
    end

    rd_chk(3'd4, 16'h0007, "R4 all flags set");
    rd_chk(3'd2, 16'h0004, "R2 bus-off bit2");
    @(negedge clk);
    check("R5 ir level holds", {13'b0, ir_out}, 16'h0005);

    // R10 reset clears everything
    rst_n = 1'b0;
    @(negedge clk);
    for (int a = 0; a < 7; a++) rd_chk(3'(a), 16'h0000, "R10 reset clears reg");
    check("R10 reset ir", {13'b0, ir_out}, 16'h0);
    check("R10 reset irq", {15'b0, irq_line}, 16'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule